// File: doc/BRIEF.md
# Serial Register Control Port

This block is a serial slave that lets an external host configure a chip. The host reaches sixteen 8-bit registers over a four-wire link made of an active-low select, a serial clock, a data input and a data output with its own output enable. The enable lets a pad cell or board-level logic float the output line whenever the block is not answering. The three link inputs are synchronised into the block's system clock. The serial clock must therefore run well below the system clock: every serial half-period spans at least five system cycles.

Every transaction opens with an address byte. Its seven upper bits are the chip address: a fixed three-bit prefix of `001` followed by the four `dev_sel` strap inputs. Its lowest bit selects the direction (0 = write, 1 = read). A write then carries a pointer byte and any number of data bytes. In the pointer byte, bit 7 enables auto-increment and bits 3:0 pick a register. The pointer stays in place between transactions. To prepare a read, the host sends a write that stops right after the pointer byte, then opens a read transaction. Register 15 is a read-only status register that reflects the `status_in` input. The other fifteen registers drive the flattened `cfg_flat` output bus.

Top module: `regport_spi`

## Requirements
- R1: While `rst` is high, all writable registers clear to 0x00, the pointer clears to 0x00 and `sdo_oe` is low.
- R2: In a write transaction with a matching address byte (bit 0 = 0), the second byte loads the pointer and each later byte is stored into the register chosen by pointer bits 3:0. `sdi` is sampled on rising `sclk` edges, MSB first.
- R3: `sdo_oe` stays low throughout any write transaction and whenever `cs_n` is high.
- R4: When pointer bit 7 is 0, the pointer does not move, so successive data bytes overwrite one register and successive read bytes repeat one register.
- R5: When pointer bit 7 is 1, pointer bits 3:0 advance by one after each byte written or read, wrapping from 15 to 0.
- R6: In a read transaction (address bit 0 = 1), the MSB of the selected register is driven and `sdo_oe` rises on the first falling `sclk` edge after the address byte. A new bit follows on every later falling edge.
- R7: Register 15 reads back the current `status_in` value. Writes aimed at it are discarded, and the other registers and the `cfg_flat` bus keep their values.
- R8: An address byte whose upper seven bits differ from {`001`, `dev_sel`} makes the block ignore the rest of the transaction: no register changes and `sdo_oe` stays low until `cs_n` goes high.
- R9: Raising `cs_n` mid-byte aborts the transfer. The partial bits are dropped, and the next transaction starts with a fresh address byte.
- R10: The pointer keeps its value across transactions, including all advances made during a read, so a later read with no set-up write continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| dev_sel | input | 4 | Strap pins forming the low four bits of the chip address |
| status_in | input | 8 | Live value returned when register 15 is read |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | High while `sdo` should be driven onto the line |
| cfg_flat | output | 128 | Register contents; register k occupies bits 8k+7:8k (slot 15 reads zero) |

## Verification
A table of single-byte write transactions covers several register indices, data patterns of alternating bits, and pointer bytes with the increment bit or the unused middle bits set. Each entry is read back through a separate set-up write and read. This separates correct pointer decoding from a mix-up of index bits. Bursts of several data bytes with the increment bit off and on show the difference between holding and stepping. The burst that starts at register 14 passes over the read-only status slot and wraps to 0. A later read with no set-up write shows whether the pointer kept its advances across transactions. Address bytes with a wrong prefix or wrong strap bits, and a transfer cut off after a few bits, must leave the registers unchanged and must not desynchronise the bit count for the transaction that follows.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int DW          = 8;
    localparam int NREG        = 16;
    localparam int AW          = $clog2(NREG);
    localparam int STATUS_IDX  = NREG - 1;
    localparam int SYNC_STAGES = 2;
    localparam int BCW         = $clog2(DW);
    localparam logic [2:0] CHIP_PREFIX = 3'b001;

    typedef logic [AW-1:0]  idx_t;
    typedef logic [DW-1:0]  byte_t;
    typedef logic [BCW-1:0] bitcnt_t;

    typedef struct packed {
        logic              inc;
        logic [DW-AW-2:0]  spare;
        idx_t              idx;
    } ptr_t;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_READ,
        ST_IGNORE
    } port_state_e;

    function automatic ptr_t ptr_step(input ptr_t p);
        ptr_t r;
        r = p;
        if (p.inc) begin
            r.idx = p.idx + idx_t'(1);
        end
        return r;
    endfunction

    function automatic logic chip_match(input byte_t b, input logic [AW-1:0] sel);
        return b[DW-1:1] == {CHIP_PREFIX, sel};
    endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/regport_regbank.sv
module regport_regbank
    import regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  byte_t              wr_data,
    input  idx_t               rd_idx,
    input  byte_t              status_in,
    output byte_t              rd_data,
    output logic [NREG*DW-1:0] cfg_flat
);
    logic [NREG-1:0][DW-1:0] slots;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_slot
            if (g == STATUS_IDX) begin : g_ro
                assign slots[g] = '0;
            end else begin : g_rw
                byte_t q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (wr_en && wr_idx == idx_t'(g)) begin
                        q <= wr_data;
                    end
                end
                assign slots[g] = q;
            end
        end
    endgenerate

    assign rd_data  = (rd_idx == idx_t'(STATUS_IDX)) ? status_in : slots[rd_idx];
    assign cfg_flat = slots;

    // R7: a write aimed at the status slot leaves the whole bank untouched
    assert_status_ro_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == idx_t'(STATUS_IDX)) |=> $stable(cfg_flat));

    // R2: a write to a writable slot lands there on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != idx_t'(STATUS_IDX)) |=> slots[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/regport_ctl.sv
module regport_ctl
    import regport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic [AW-1:0] dev_sel,
    input  byte_t         rd_data,
    output logic          wr_en,
    output idx_t          wr_idx,
    output byte_t         wr_data,
    output idx_t          rd_idx,
    output logic          sdo,
    output logic          sdo_oe
);
    port_state_e state_q;
    bitcnt_t     bitcnt_q;
    bitcnt_t     rcnt_q;
    byte_t       shin_q;
    byte_t       obuf_q;
    ptr_t        ptr_q;
    ptr_t        ptr_nx;
    logic        sclk_d;
    logic        sdo_q;
    logic        oe_q;

    logic  active;
    logic  rise;
    logic  fall;
    logic  shifting;
    logic  byte_done;
    byte_t next_byte;

    assign active    = ~cs_n_s;
    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);
    assign next_byte = {shin_q[DW-2:0], sdi_s};
    assign byte_done = active && rise && shifting && (bitcnt_q == bitcnt_t'(DW-1));
    assign ptr_nx    = ptr_step(ptr_q);

    assign wr_en   = byte_done && (state_q == ST_WDATA);
    assign wr_idx  = ptr_q.idx;
    assign wr_data = next_byte;
    assign rd_idx  = (state_q == ST_READ) ? ptr_nx.idx : ptr_q.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            rcnt_q   <= '0;
            shin_q   <= '0;
            obuf_q   <= '0;
            ptr_q    <= '0;
            sclk_d   <= 1'b0;
            sdo_q    <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (!active) begin
                state_q  <= ST_ADDR;
                bitcnt_q <= '0;
                rcnt_q   <= '0;
                oe_q     <= 1'b0;
            end else begin
                if (rise && shifting) begin
                    shin_q   <= next_byte;
                    bitcnt_q <= bitcnt_q + bitcnt_t'(1);
                end
                if (byte_done) begin
                    case (state_q)
                        ST_ADDR: begin
                            if (!chip_match(next_byte, dev_sel)) begin
                                state_q <= ST_IGNORE;
                            end else if (next_byte[0]) begin
                                state_q <= ST_READ;
                                obuf_q  <= rd_data;
                                rcnt_q  <= '0;
                            end else begin
                                state_q <= ST_PTR;
                            end
                        end
                        ST_PTR: begin
                            ptr_q   <= ptr_t'(next_byte);
                            state_q <= ST_WDATA;
                        end
                        ST_WDATA: ptr_q <= ptr_nx;
                        default: ;
                    endcase
                end
                if (fall && state_q == ST_READ) begin
                    oe_q   <= 1'b1;
                    sdo_q  <= obuf_q[DW-1];
                    rcnt_q <= rcnt_q + bitcnt_t'(1);
                    if (rcnt_q == bitcnt_t'(DW-1)) begin
                        ptr_q  <= ptr_nx;
                        obuf_q <= rd_data;
                    end else begin
                        obuf_q <= {obuf_q[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sdo    = sdo_q;
    assign sdo_oe = oe_q;

    // R1: reset clears pointer, framing and output enable
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ptr_q == '0 && !oe_q && state_q == ST_ADDR));

    // R3: output enable drops once select is released
    assert_oe_off_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !active |=> !oe_q);

    // R6: output is only enabled in a read, and first rises on a falling sclk
    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> state_q == ST_READ);
    assert_oe_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(fall));

    // R4: increment off keeps the pointer fixed across a data byte
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ptr_q.inc) |=> $stable(ptr_q));

    // R5: increment on steps the index by one, wrapping
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q.inc) |=> ptr_q.idx == idx_t'($past(ptr_q.idx) + 1'b1));

    // R8: an ignored transaction neither writes nor drives
    assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IGNORE) |-> (!wr_en && !oe_q));
endmodule

// File: rtl/regport_spi.sv
module regport_spi
    import regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic [AW-1:0]      dev_sel,
    input  logic [DW-1:0]      status_in,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [NREG*DW-1:0] cfg_flat
);
    logic  cs_n_s;
    logic  sclk_s;
    logic  sdi_s;
    logic  wr_en;
    idx_t  wr_idx;
    byte_t wr_data;
    idx_t  rd_idx;
    byte_t rd_data;

    regport_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi}),
        .q   ({cs_n_s, sclk_s, sdi_s})
    );

    regport_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .cs_n_s  (cs_n_s),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .dev_sel (dev_sel),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    regport_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .status_in (status_in),
        .rd_data   (rd_data),
        .cfg_flat  (cfg_flat)
    );
endmodule

// File: tb/sim_regport_spi.sv
module sim_regport_spi;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [7:0] ADDR_W = 8'h34;
    localparam logic [7:0] ADDR_R = 8'h35;
    localparam logic [7:0] STATUS = 8'hC3;
    localparam int NVEC = 6;
    // {pointer byte, data byte, expected read-back}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h03, 8'hA5, 8'hA5},
        {8'h00, 8'h5A, 8'h5A},
        {8'h0E, 8'hFF, 8'hFF},
        {8'h0F, 8'h33, STATUS},
        {8'h89, 8'h81, 8'h81},
        {8'h7C, 8'h3C, 8'h3C}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [3:0]   dev_sel = 4'hA;
    logic [7:0]   status_in = STATUS;
    logic         sdo;
    logic         sdo_oe;
    logic [127:0] cfg_flat;

    int checks = 0;
    int errors = 0;
    int wr_oe_bad = 0;
    int mm_oe_bad = 0;
    logic in_write = 1'b0;
    logic in_mm = 1'b0;
    logic done = 1'b0;

    regport_spi u0 (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .dev_sel   (dev_sel),
        .status_in (status_in),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .cfg_flat  (cfg_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (in_write && sdo_oe) wr_oe_bad++;
        if (in_mm && sdo_oe)    mm_oe_bad++;
    end

    function automatic logic [7:0] slot(input int k);
        return cfg_flat[k*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic b, output logic r, output logic oe);
        @(negedge clk);
        sdi = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        r  = sdo;
        oe = sdo_oe;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic r, oe;
        for (int i = 7; i > 7 - n; i--) bit_xfer(b[i], r, oe);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic recv_byte(output logic [7:0] v, output logic oe_all);
        logic r, oe;
        oe_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b0, r, oe);
            v = {v[6:0], r};
            oe_all = oe_all & oe;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        in_write = 1'b1;
        cs_begin();
        send_byte(ADDR_W);
        send_byte(p);
        cs_end();
        in_write = 1'b0;
    endtask

    task automatic write1(input logic [7:0] p, input logic [7:0] d);
        in_write = 1'b1;
        cs_begin();
        send_byte(ADDR_W);
        send_byte(p);
        send_byte(d);
        cs_end();
        in_write = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 sdo_oe in reset", {7'd0, sdo_oe}, 8'h00);
        check("R1 cfg zero in reset", (cfg_flat == '0) ? 8'h01 : 8'h00, 8'h01);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Table walk: R2 single writes, R6 reads, R7 status slot
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] p, d, e;
            {p, d, e} = VEC[k];
            write1(p, d);
            if (p[3:0] != 4'hF) check("R2 table write slot", slot(int'(p[3:0])), d);
            else check("R7 status slot stays zero", slot(15), 8'h00);
            set_ptr(p);
            cs_begin();
            send_byte(ADDR_R);
            recv_byte(v, oe);
            cs_end();
            check("R6 table read value", v, e);
            check("R6 sdo_oe during read", {7'd0, oe}, 8'h01);
        end
        check("R7 other regs after status write", slot(14), 8'hFF);

        // R4: increment off, burst overwrites one register, reads repeat
        in_write = 1'b1;
        cs_begin();
        send_byte(ADDR_W); send_byte(8'h04);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        cs_end();
        in_write = 1'b0;
        check("R4 last byte wins", slot(4), 8'h33);
        check("R4 neighbour untouched", slot(5), 8'h00);
        set_ptr(8'h04);
        cs_begin();
        send_byte(ADDR_R);
        recv_byte(v, oe); check("R4 read byte 0", v, 8'h33);
        recv_byte(v, oe); check("R4 read byte 1", v, 8'h33);
        cs_end();

        // R5: increment on, wrap across status slot
        in_write = 1'b1;
        cs_begin();
        send_byte(ADDR_W); send_byte(8'h8E);
        send_byte(8'hE1); send_byte(8'hF2); send_byte(8'h03); send_byte(8'h6D);
        cs_end();
        in_write = 1'b0;
        check("R5 burst reg14", slot(14), 8'hE1);
        check("R5 burst wrap reg0", slot(0), 8'h03);
        check("R5 burst reg1", slot(1), 8'h6D);
        check("R7 burst status slot", slot(15), 8'h00);
        set_ptr(8'h8E);
        cs_begin();
        send_byte(ADDR_R);
        recv_byte(v, oe); check("R5 read reg14", v, 8'hE1);
        recv_byte(v, oe); check("R7 read status", v, STATUS);
        recv_byte(v, oe); check("R5 read wrap reg0", v, 8'h03);
        cs_end();

        // R10: pointer advanced three times during that read, now at reg1
        cs_begin();
        send_byte(ADDR_R);
        recv_byte(v, oe);
        cs_end();
        check("R10 read continues without set-up", v, 8'h6D);

        // R8: mismatched strap bits and mismatched prefix
        in_mm = 1'b1;
        cs_begin();
        send_byte({3'b001, 4'h5, 1'b0}); send_byte(8'h02); send_byte(8'h99);
        cs_end();
        cs_begin();
        send_byte({3'b010, 4'hA, 1'b0}); send_byte(8'h02); send_byte(8'h98);
        cs_end();
        cs_begin();
        send_byte({3'b001, 4'hB, 1'b1}); send_byte(8'h00); send_byte(8'h00);
        cs_end();
        in_mm = 1'b0;
        check("R8 reg2 unchanged", slot(2), 8'h00);
        check("R8 sdo_oe stayed low", mm_oe_bad[7:0], 8'h00);

        // R9: abort mid-byte, then a clean transaction
        write1(8'h05, 8'h11);
        in_write = 1'b1;
        cs_begin();
        send_byte(ADDR_W);
        send_bits(8'hFF, 3);
        cs_end();
        in_write = 1'b0;
        write1(8'h06, 8'h22);
        check("R9 reg6 after abort", slot(6), 8'h22);
        check("R9 reg5 kept", slot(5), 8'h11);

        // R3: no output enable during any write transaction
        check("R3 sdo_oe low in writes", wr_oe_bad[7:0], 8'h00);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cfg zero after reset", (cfg_flat == '0) ? 8'h01 : 8'h00, 8'h01);
        check("R1 sdo_oe after reset", {7'd0, sdo_oe}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule